// File: doc/BRIEF.md
# GPIO Register Block

A 32-bit general-purpose I/O controller that sits behind a simple word-addressed register bus. Software programs which pins are outputs through a direction register, reads the pin level register back, and changes levels only through two write-only strobe locations: one that sets bits and one that clears them. A set or clear write is applied only when its mask touches at least one pin configured as an output. When it does, the whole mask is applied, including bits for input pins. When it does not, the write is dropped and a one-cycle error pulse is raised. A spare read/write register is available for software use.

Three edge-control locations accept writes and discard them. Reads of any location that has no readable register return zero. Nine interrupt outputs are present, eight for the low pin group and one for the high group, and all of them are held low. The level register holds only what software wrote; no external pins are sampled. Write strobes last one cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_regblk`

## Requirements
- R1: After reset the level register, the direction register and the spare register all read zero, and `rdata` and `wr_err` are low.
- R2: Offset 0x00 reads the level register. Offset 0x04 is the direction register and can be read and written; a 1 bit marks an output pin.
- R3: A write to offset 0x08 with `(wdata & direction) != 0` ORs the entire `wdata` into the level register.
- R4: A write to offset 0x0C with `(wdata & direction) != 0` clears every bit of the level register that is 1 in `wdata`.
- R5: A write to 0x08 or 0x0C with `(wdata & direction) == 0` leaves the level register unchanged and drives `wr_err` high for exactly the one cycle after the write edge. Every other write leaves `wr_err` low.
- R6: Offset 0x20 is a spare register that can be read and written.
- R7: Writes to 0x10, 0x14 and 0x18 change no register. Writes to any other unmapped offset also change nothing. Reads of 0x08, 0x0C, 0x10, 0x14, 0x18 and of any unmapped offset return zero.
- R8: An address with either of its two low bits set is treated as unmapped, so its writes are ignored and its reads return zero.
- R9: `rdata` takes the selected value on the clock edge that samples `rd_en`, and it shows the register contents from before any write in the same cycle. `rdata` holds its value in cycles with no read.
- R10: All eight `irq_low` bits and `irq_high` stay low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wr_err | output | 1 | Pulse for a rejected set or clear write |
| irq_low | output | 8 | Low-group interrupt lines, held low |
| irq_high | output | 1 | High-group interrupt line, held low |

## Verification
The set and clear strobes are tried with four kinds of mask:
- a mask written while no pin is an output, which separates the overlap gate from an unconditional update;
- a mask that overlaps outputs in only one bit while also covering input bits, which shows whether the whole mask or only its output bits is applied;
- a mask confined to input pins, which must be rejected even though the direction register is non-zero;
- a clear mask that mixes bits that are already set with bits that are already clear.

Writes to the edge slots, to an unmapped offset and to a misaligned offset are each followed by a read-back of every real register. This separates an ignored write from one that aliases onto a register. A read and a write to the same location in one cycle tell pre-write from post-write read data.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;

   localparam int unsigned OFF_LEVEL = 32'h00;
   localparam int unsigned OFF_DIR   = 32'h04;
   localparam int unsigned OFF_SET   = 32'h08;
   localparam int unsigned OFF_CLR   = 32'h0C;
   localparam int unsigned OFF_RISE  = 32'h10;
   localparam int unsigned OFF_FALL  = 32'h14;
   localparam int unsigned OFF_EDGE  = 32'h18;
   localparam int unsigned OFF_SPARE = 32'h20;

   // Highest offset in use; the address must reach it.
   localparam int unsigned OFF_TOP   = OFF_SPARE;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LEVEL,
      SEL_DIR,
      SEL_SET,
      SEL_CLR,
      SEL_EDGECTL,
      SEL_SPARE
   } gpio_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_regblk_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output gpio_sel_e         sel
);

   localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFF_LEVEL);
   localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFF_DIR);
   localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFF_SET);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFF_CLR);
   localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(OFF_RISE);
   localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(OFF_FALL);
   localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(OFF_EDGE);
   localparam logic [ADDR_W-1:0] A_SPARE = ADDR_W'(OFF_SPARE);

   always_comb begin
      sel = SEL_NONE;
      // Only whole-word accesses: a misaligned offset maps to nothing.
      if (addr[1:0] == 2'b00) begin
         case (addr)
            A_LEVEL: sel = SEL_LEVEL;
            A_DIR:   sel = SEL_DIR;
            A_SET:   sel = SEL_SET;
            A_CLR:   sel = SEL_CLR;
            A_RISE,
            A_FALL,
            A_EDGE:  sel = SEL_EDGECTL;
            A_SPARE: sel = SEL_SPARE;
            default: sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/gpio_pin_state.sv
module gpio_pin_state
   import gpio_regblk_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  gpio_sel_e         sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] level_q,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] spare_q,
   output logic              err_q
);

   logic hits_output;
   logic is_strobe;

   assign hits_output = |(wdata & dir_q);
   assign is_strobe   = wr_en && ((sel == SEL_SET) || (sel == SEL_CLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         dir_q   <= '0;
         spare_q <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= is_strobe && !hits_output;
         if (wr_en) begin
            case (sel)
               SEL_DIR:   dir_q   <= wdata;
               SEL_SPARE: spare_q <= wdata;
               SEL_SET:   if (hits_output) level_q <= level_q | wdata;
               SEL_CLR:   if (hits_output) level_q <= level_q & ~wdata;
               default:   ;
            endcase
         end
      end
   end

endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
   import gpio_regblk_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  gpio_sel_e         sel,
   input  logic [DATA_W-1:0] level,
   input  logic [DATA_W-1:0] dir,
   input  logic [DATA_W-1:0] spare,
   output logic [DATA_W-1:0] rdata_q
);

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      case (sel)
         SEL_LEVEL: rd_mux = level;
         SEL_DIR:   rd_mux = dir;
         SEL_SPARE: rd_mux = spare;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
   import gpio_regblk_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NUM_LOW_IRQ = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic                   wr_err,
   output logic [NUM_LOW_IRQ-1:0] irq_low,
   output logic                   irq_high
);

   localparam int unsigned MIN_ADDR_W = $clog2(OFF_TOP + 4);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("gpio_regblk: ADDR_W too small for the register map");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("gpio_regblk: DATA_W must be at least 1");
   end
   if (NUM_LOW_IRQ < 1) begin : g_bad_irq_n
      $error("gpio_regblk: NUM_LOW_IRQ must be at least 1");
   end

   gpio_sel_e         sel;
   logic [DATA_W-1:0] level_q;
   logic [DATA_W-1:0] dir_q;
   logic [DATA_W-1:0] spare_q;

   gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   gpio_pin_state #(.DATA_W(DATA_W)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .sel     (sel),
      .wdata   (wdata),
      .level_q (level_q),
      .dir_q   (dir_q),
      .spare_q (spare_q),
      .err_q   (wr_err)
   );

   gpio_rd_port #(.DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .sel     (sel),
      .level   (level_q),
      .dir     (dir_q),
      .spare   (spare_q),
      .rdata_q (rdata)
   );

   // Interrupt lines are wired but have no source yet.
   for (genvar i = 0; i < NUM_LOW_IRQ; i++) begin : g_irq_low
      assign irq_low[i] = 1'b0;
   end
   assign irq_high = 1'b0;

endmodule

// File: rtl/gpio_regblk_chk.sv
module gpio_regblk_chk
   import gpio_regblk_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NUM_LOW_IRQ = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic                   rd_en,
   input logic [ADDR_W-1:0]      addr,
   input logic [DATA_W-1:0]      wdata,
   input logic [DATA_W-1:0]      rdata,
   input logic                   wr_err,
   input logic [NUM_LOW_IRQ-1:0] irq_low,
   input logic                   irq_high,
   input logic [DATA_W-1:0]      level_q,
   input logic [DATA_W-1:0]      dir_q
);

   logic set_wr;
   logic clr_wr;
   assign set_wr = wr_en && (addr == ADDR_W'(OFF_SET));
   assign clr_wr = wr_en && (addr == ADDR_W'(OFF_CLR));

   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_low == '0) && !irq_high)
      else $error("irq line active");

   p_err_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(set_wr || clr_wr))
      else $error("wr_err without a strobe write");

   p_err_keeps_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> (level_q == $past(level_q)))
      else $error("rejected write changed level");

   p_set_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wr && ((wdata & dir_q) != '0)) |=> (level_q == ($past(level_q) | $past(wdata))))
      else $error("set write not applied");

   p_clr_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && ((wdata & dir_q) != '0)) |=> (level_q == ($past(level_q) & ~$past(wdata))))
      else $error("clear write not applied");

   p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata))
      else $error("rdata moved without a read");

   p_level_only_by_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_wr || clr_wr) |=> $stable(level_q))
      else $error("level changed without a strobe write");

endmodule

bind gpio_regblk gpio_regblk_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .NUM_LOW_IRQ (NUM_LOW_IRQ)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .wr_err   (wr_err),
   .irq_low  (irq_low),
   .irq_high (irq_high),
   .level_q  (level_q),
   .dir_q    (dir_q)
);

// File: tb/gpio_regblk_tb_top.sv
`timescale 1ns/1ps
module gpio_regblk_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        wr_err;
   logic [7:0]  irq_low;
   logic        irq_high;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   gpio_regblk dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .wr_err   (wr_err),
      .irq_low  (irq_low),
      .irq_high (irq_high)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  adr;
      logic [31:0] dat;
      logic [31:0] exp;
      logic        err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 level zero
      '{1'b0, 8'h04, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 dir zero
      '{1'b0, 8'h20, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 spare zero
      '{1'b1, 8'h08, 32'h000000FF, 32'h0,        1'b1, 4'd5},  // R5 no outputs yet
      '{1'b0, 8'h00, 32'h0,        32'h0,        1'b0, 4'd5},  // R5 level unchanged
      '{1'b1, 8'h04, 32'h0000000F, 32'h0,        1'b0, 4'd2},  // R2 dir write
      '{1'b0, 8'h04, 32'h0,        32'h0000000F, 1'b0, 4'd2},  // R2 dir read
      '{1'b1, 8'h08, 32'h00000F01, 32'h0,        1'b0, 4'd3},  // R3 one-bit overlap
      '{1'b0, 8'h00, 32'h0,        32'h00000F01, 1'b0, 4'd3},  // R3 whole mask set
      '{1'b1, 8'h0C, 32'h00000F00, 32'h0,        1'b1, 4'd5},  // R5 input-only clear
      '{1'b0, 8'h00, 32'h0,        32'h00000F01, 1'b0, 4'd5},  // R5 unchanged
      '{1'b1, 8'h0C, 32'h00000301, 32'h0,        1'b0, 4'd4},  // R4 clear mixed
      '{1'b0, 8'h00, 32'h0,        32'h00000C00, 1'b0, 4'd4},  // R4 result
      '{1'b1, 8'h20, 32'hDEADBEEF, 32'h0,        1'b0, 4'd6},  // R6 spare write
      '{1'b0, 8'h20, 32'h0,        32'hDEADBEEF, 1'b0, 4'd6},  // R6 spare read
      '{1'b1, 8'h10, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd7},  // R7 edge slot
      '{1'b1, 8'h14, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd7},  // R7 edge slot
      '{1'b1, 8'h18, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd7},  // R7 edge slot
      '{1'b0, 8'h10, 32'h0,        32'h0,        1'b0, 4'd7},  // R7 read zero
      '{1'b0, 8'h18, 32'h0,        32'h0,        1'b0, 4'd7},  // R7 read zero
      '{1'b0, 8'h08, 32'h0,        32'h0,        1'b0, 4'd7},  // R7 set slot reads 0
      '{1'b0, 8'h0C, 32'h0,        32'h0,        1'b0, 4'd7},  // R7 clr slot reads 0
      '{1'b1, 8'h24, 32'h12345678, 32'h0,        1'b0, 4'd7},  // R7 unmapped write
      '{1'b0, 8'h24, 32'h0,        32'h0,        1'b0, 4'd7},  // R7 unmapped read
      '{1'b1, 8'h21, 32'h00000000, 32'h0,        1'b0, 4'd8},  // R8 misaligned spare
      '{1'b1, 8'h05, 32'h000000FF, 32'h0,        1'b0, 4'd8},  // R8 misaligned dir
      '{1'b0, 8'h20, 32'h0,        32'hDEADBEEF, 1'b0, 4'd8},  // R8 spare intact
      '{1'b0, 8'h04, 32'h0,        32'h0000000F, 1'b0, 4'd8},  // R8 dir intact
      '{1'b0, 8'h01, 32'h0,        32'h0,        1'b0, 4'd8}   // R8 misaligned read
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one access for one cycle; return after the next falling edge.
   task automatic access(input bit wr, input bit rd, input logic [7:0] a,
                         input logic [31:0] d);
      @(negedge clk);
      wr_en = wr; rd_en = rd; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check(rdata == 32'h0, "R1", rdata, 32'h0);
      check(wr_err == 1'b0, "R1", {31'h0, wr_err}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         access(VECS[i].wr, !VECS[i].wr, VECS[i].adr, VECS[i].dat);
         if (!VECS[i].wr)
            check(rdata == VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i),
                  rdata, VECS[i].exp);
         check(wr_err == VECS[i].err, $sformatf("R%0d vec%0d err", VECS[i].req, i),
               {31'h0, wr_err}, {31'h0, VECS[i].err});
      end

      // R10: interrupt lines quiet
      check({irq_high, irq_low} == 9'h0, "R10", {23'h0, irq_high, irq_low}, 32'h0);

      // R9: same-cycle read and write returns the old value
      access(1'b1, 1'b1, 8'h04, 32'h000000FF);
      check(rdata == 32'h0000000F, "R9 old value", rdata, 32'h0000000F);
      access(1'b0, 1'b1, 8'h04, 32'h0);
      check(rdata == 32'h000000FF, "R2 new dir", rdata, 32'h000000FF);
      // R9: rdata holds across idle cycles
      repeat (2) @(negedge clk);
      check(rdata == 32'h000000FF, "R9 hold", rdata, 32'h000000FF);

      // R5: one-cycle pulse, then low
      access(1'b1, 1'b0, 8'h08, 32'h00000100);
      check(wr_err == 1'b1, "R5 pulse", {31'h0, wr_err}, 32'h1);
      @(negedge clk);
      check(wr_err == 1'b0, "R5 pulse end", {31'h0, wr_err}, 32'h0);
      access(1'b0, 1'b1, 8'h00, 32'h0);
      check(rdata == 32'h00000C00, "R5 level kept", rdata, 32'h00000C00);

      // R3: set inside outputs only
      access(1'b1, 1'b0, 8'h08, 32'h00000081);
      check(wr_err == 1'b0, "R3 no err", {31'h0, wr_err}, 32'h0);
      access(1'b0, 1'b1, 8'h00, 32'h0);
      check(rdata == 32'h00000C81, "R3 set", rdata, 32'h00000C81);

      // R1: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(rdata == 32'h0, "R1 rdata", rdata, 32'h0);
      rst_n = 1'b1;
      access(1'b0, 1'b1, 8'h00, 32'h0);
      check(rdata == 32'h0, "R1 level", rdata, 32'h0);
      access(1'b0, 1'b1, 8'h04, 32'h0);
      check(rdata == 32'h0, "R1 dir", rdata, 32'h0);
      access(1'b0, 1'b1, 8'h20, 32'h0);
      check(rdata == 32'h0, "R1 spare", rdata, 32'h0);
      access(1'b1, 1'b0, 8'h0C, 32'hFFFFFFFF);
      check(wr_err == 1'b1, "R5 after reset", {31'h0, wr_err}, 32'h1);
      check({irq_high, irq_low} == 9'h0, "R10 end", {23'h0, irq_high, irq_low}, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule